// File: doc/BRIEF.md
# Emulation Freeze and Statistics Controller

This block sits beside the supervisor processor of a multi-core emulation platform. A programmable interval timer, clocked by the supervisor clock and never gated itself, raises an interrupt at a fixed period. At each interrupt the block asks every emulated core to stop. Each core's bus clock enable drops only on a cycle where that core reports its bus as idle, so no bus transfer is cut in half. The per-core statistics counters (enabled cycles and counted events) advance only while that core's clock runs. Counters and clocks therefore stop and resume together, and the cores never see the pause.

While the system is frozen, the supervisor reads the counters and each core's current frequency setting over a simple word-addressed register port. It writes new temperature values into a shadow bank, then issues a release command. The release copies the shadow bank to the sensor outputs that the cores read, and it re-enables every clock. An acknowledge command clears the interrupt and restarts the interval.

The interval is set in ticks of a prescaled supervisor clock. With the default parameters one tick is 1 ms and the legal range is 10 ms to 1 s.

Top module: `emu_freeze_ctrl`

## Requirements
- R1: After reset, `irq` and `frozen` are 0, all `core_clk_en` bits are 1, `sensor_temp` is all zero, the temperature shadow registers read 0 and the interval register (word 0x01) reads MIN_TICKS.
- R2: While `irq` is low the timer counts supervisor cycles. `irq` rises exactly interval×PRESCALE cycles after the write that reset the timer (reset release or an acknowledge), and the timer does not count while `irq` is high.
- R3: A write to word 0x01 stores the value clamped to the range [MIN_TICKS, MAX_TICKS]. A read returns the stored value.
- R4: `irq` stays high until the supervisor writes word 0x00 with bit 0 (acknowledge) set. That write clears `irq` and restarts the interval from zero.
- R5: When the timer fires, a freeze request is raised. Each core's `core_clk_en` drops at the first clock edge at which the request is pending and that core's `core_bus_idle` is high. A core whose bus stays busy keeps running. `frozen` is high exactly when all `core_clk_en` bits are 0.
- R6: A gated core stays gated until word 0x00 is written with bit 1 (release) set. An acknowledge without release leaves the cores gated. A release re-enables every core at the next edge.
- R7: For core c, the cycle counter (word 0x10+c) increments at each edge at which `core_clk_en[c]` is high. The event counter (word 0x20+c) increments at each such edge at which `core_event[c]` is high. Both counters hold still while the core is gated.
- R8: Counters saturate at all ones (CNT_W bits) instead of wrapping. Any write to a counter word clears that counter.
- R9: Word 0x30+c returns the current value of core c's frequency setting input.
- R10: A write to word 0x40+c updates the temperature shadow at once, and reads return the new value. `sensor_temp` (core c at bits [c*TEMP_W +: TEMP_W]) changes only on a release write, which loads it from the shadow bank.
- R11: A read of word 0x00 returns bit 0 = `irq`, bit 1 = `frozen` and bit 2 = freeze request pending. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock (never gated) |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Word address: page in [7:4], core index in [3:0] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Interval interrupt to the supervisor |
| frozen | output | 1 | All core clocks gated |
| core_bus_idle | input | N_CORES | Per-core bus idle indication |
| core_event | input | N_CORES | Per-core countable event |
| core_freq | input | N_CORES*FREQ_W | Per-core current frequency setting |
| core_clk_en | output | N_CORES | Per-core bus clock enable |
| sensor_temp | output | N_CORES*TEMP_W | Temperatures visible to the cores |

## Verification
The hardest state to reach from the ports is a staggered freeze. In it, one core has stopped while another is still running because its bus is busy, and the running core's counters must keep advancing until its own idle cycle. The bench reaches this state by holding one core's idle input low for a chosen number of cycles after the interrupt, including one long hold. It checks the partial clock enables during the hold, then the exact cycle at which the core gates. The long hold also drives the cycle counter past its maximum, so saturation is exercised in the same run. Each expected count comes from the interval, the prescale factor and the hold length.

// File: rtl/emu_freeze_pkg.sv
// Package: register map constants and command encoding shared by the
// freeze controller and its checker.
package emu_freeze_pkg;
    localparam logic [7:0] ADDR_STATUS   = 8'h00;
    localparam logic [7:0] ADDR_INTERVAL = 8'h01;
    localparam logic [3:0] PAGE_CYCLE    = 4'h1;
    localparam logic [3:0] PAGE_EVENT    = 4'h2;
    localparam logic [3:0] PAGE_FREQ     = 4'h3;
    localparam logic [3:0] PAGE_TEMP     = 4'h4;

    // Command bits written to the status word.
    typedef struct packed {
        logic rel;  // bit 1: restore clocks, publish temperatures
        logic ack;  // bit 0: clear interrupt, restart interval
    } ctrl_cmd_t;
endpackage

// File: rtl/emu_interval_timer.sv
// Interval timer: counts supervisor cycles through a prescaler and raises
// irq after the programmed number of ticks. Assumes clk is never gated.
// Holds while irq is high; an acknowledge clears irq and restarts.
module emu_interval_timer #(
    parameter int PRESCALE  = 100000,
    parameter int MIN_TICKS = 10,
    parameter int MAX_TICKS = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        interval_wr,
    input  logic [31:0] interval_wdata,
    input  logic        ack,
    output logic [31:0] interval,
    output logic        irq,
    output logic        fire
);
    localparam int TICK_W = $clog2(MAX_TICKS + 1);
    localparam int PRE_W  = $clog2(PRESCALE + 1);

    logic [PRE_W-1:0]  pre_q;
    logic [TICK_W-1:0] tick_q;
    logic [TICK_W-1:0] ival_q;
    logic              irq_q;
    logic              last_pre;

    function automatic logic [TICK_W-1:0] clamp_ival(input logic [31:0] v);
        if (v < 32'(MIN_TICKS))      return TICK_W'(MIN_TICKS);
        else if (v > 32'(MAX_TICKS)) return TICK_W'(MAX_TICKS);
        else                         return v[TICK_W-1:0];
    endfunction

    assign last_pre = (pre_q == PRE_W'(PRESCALE - 1));
    assign fire     = !irq_q && !ack && last_pre &&
                      (({1'b0, tick_q} + (TICK_W+1)'(1)) >= {1'b0, ival_q});
    assign irq      = irq_q;
    assign interval = {{(32-TICK_W){1'b0}}, ival_q};

    // Interval register with range clamp.
    always_ff @(posedge clk) begin
        if (!rst_n)           ival_q <= TICK_W'(MIN_TICKS);
        else if (interval_wr) ival_q <= clamp_ival(interval_wdata);
    end

    // Prescaler, tick counter and interrupt flag.
    always_ff @(posedge clk) begin
        if (!rst_n || ack) begin
            pre_q  <= '0;
            tick_q <= '0;
            irq_q  <= 1'b0;
        end else if (fire) begin
            pre_q  <= '0;
            tick_q <= '0;
            irq_q  <= 1'b1;
        end else if (!irq_q) begin
            if (last_pre) begin
                pre_q  <= '0;
                tick_q <= tick_q + TICK_W'(1);
            end else begin
                pre_q  <= pre_q + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/emu_core_stats.sv
// Per-core clock gate and statistics: gates the core's bus clock on an idle
// cycle once a freeze is requested and counts enabled cycles and events
// with saturation. Assumes release has priority over a new gate request.
module emu_core_stats #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze_req,
    input  logic             rel,
    input  logic             bus_idle,
    input  logic             event_in,
    input  logic             clr_cycle,
    input  logic             clr_event,
    output logic             clk_en,
    output logic [CNT_W-1:0] cyc_cnt,
    output logic [CNT_W-1:0] evt_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic gated_q;

    assign clk_en = !gated_q;

    // Gate on an idle bus boundary; release reopens.
    always_ff @(posedge clk) begin
        if (!rst_n || rel)              gated_q <= 1'b0;
        else if (freeze_req && bus_idle) gated_q <= 1'b1;
    end

    // Enabled-cycle counter, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_cycle)              cyc_cnt <= '0;
        else if (!gated_q && cyc_cnt != CNT_MAX) cyc_cnt <= cyc_cnt + CNT_W'(1);
    end

    // Event counter, saturating, counts only while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_event) evt_cnt <= '0;
        else if (!gated_q && event_in && evt_cnt != CNT_MAX)
            evt_cnt <= evt_cnt + CNT_W'(1);
    end
endmodule

// File: rtl/emu_sensor_bank.sv
// Temperature registers: a shadow bank written by the supervisor and a
// visible bank seen by the cores, loaded from the shadow on release.
module emu_sensor_bank #(
    parameter int N_CORES = 4,
    parameter int TEMP_W  = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N_CORES-1:0]               wr_en,
    input  logic [TEMP_W-1:0]                wdata,
    input  logic                             rel,
    output logic [N_CORES-1:0][TEMP_W-1:0]   shadow,
    output logic [N_CORES-1:0][TEMP_W-1:0]   visible
);
    // Shadow registers update immediately on write.
    always_ff @(posedge clk) begin
        if (!rst_n) shadow <= '0;
        else begin
            for (int c = 0; c < N_CORES; c++)
                if (wr_en[c]) shadow[c] <= wdata;
        end
    end

    // Visible registers follow the shadow only at release.
    always_ff @(posedge clk) begin
        if (!rst_n)   visible <= '0;
        else if (rel) visible <= shadow;
    end
endmodule

// File: rtl/emu_freeze_ctrl.sv
// Top level: register decode, freeze request and read multiplexer around
// the interval timer, per-core gates/counters and the sensor bank.
// Assumes N_CORES <= 16 (core index in reg_addr[3:0]), CNT_W, TEMP_W and
// FREQ_W <= 32.
module emu_freeze_ctrl
    import emu_freeze_pkg::*;
#(
    parameter int N_CORES   = 4,
    parameter int CNT_W     = 32,
    parameter int FREQ_W    = 8,
    parameter int TEMP_W    = 16,
    parameter int PRESCALE  = 100000,
    parameter int MIN_TICKS = 10,
    parameter int MAX_TICKS = 1000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [7:0]                 reg_addr,
    input  logic [31:0]                reg_wdata,
    output logic [31:0]                reg_rdata,
    output logic                       irq,
    output logic                       frozen,
    input  logic [N_CORES-1:0]         core_bus_idle,
    input  logic [N_CORES-1:0]         core_event,
    input  logic [N_CORES*FREQ_W-1:0]  core_freq,
    output logic [N_CORES-1:0]         core_clk_en,
    output logic [N_CORES*TEMP_W-1:0]  sensor_temp
);
    ctrl_cmd_t                         cmd;
    logic                              wr_status, wr_interval;
    logic                              do_ack, do_rel;
    logic                              fire, freeze_req_q;
    logic [31:0]                       interval;
    logic [3:0]                        page, idx;
    logic [N_CORES-1:0]                clr_cyc, clr_evt, wr_temp;
    logic [N_CORES-1:0][CNT_W-1:0]     cyc_cnt, evt_cnt;
    logic [N_CORES-1:0][TEMP_W-1:0]    shadow, visible;

    assign page        = reg_addr[7:4];
    assign idx         = reg_addr[3:0];
    assign cmd         = ctrl_cmd_t'(reg_wdata[1:0]);
    assign wr_status   = reg_wr && (reg_addr == ADDR_STATUS);
    assign wr_interval = reg_wr && (reg_addr == ADDR_INTERVAL);
    assign do_ack      = wr_status && cmd.ack;
    assign do_rel      = wr_status && cmd.rel;
    assign frozen      = ~|core_clk_en;
    assign sensor_temp = visible;

    // Per-core write strobes decoded from page and index.
    always_comb begin
        for (int c = 0; c < N_CORES; c++) begin
            clr_cyc[c] = reg_wr && page == PAGE_CYCLE && idx == 4'(c);
            clr_evt[c] = reg_wr && page == PAGE_EVENT && idx == 4'(c);
            wr_temp[c] = reg_wr && page == PAGE_TEMP  && idx == 4'(c);
        end
    end

    // Freeze request: raised by the timer, dropped by release.
    always_ff @(posedge clk) begin
        if (!rst_n)      freeze_req_q <= 1'b0;
        else if (fire)   freeze_req_q <= 1'b1;
        else if (do_rel) freeze_req_q <= 1'b0;
    end

    emu_interval_timer #(
        .PRESCALE (PRESCALE),
        .MIN_TICKS(MIN_TICKS),
        .MAX_TICKS(MAX_TICKS)
    ) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .interval_wr   (wr_interval),
        .interval_wdata(reg_wdata),
        .ack           (do_ack),
        .interval      (interval),
        .irq           (irq),
        .fire          (fire)
    );

    for (genvar c = 0; c < N_CORES; c++) begin : g_core
        emu_core_stats #(.CNT_W(CNT_W)) u_stats (
            .clk       (clk),
            .rst_n     (rst_n),
            .freeze_req(freeze_req_q),
            .rel       (do_rel),
            .bus_idle  (core_bus_idle[c]),
            .event_in  (core_event[c]),
            .clr_cycle (clr_cyc[c]),
            .clr_event (clr_evt[c]),
            .clk_en    (core_clk_en[c]),
            .cyc_cnt   (cyc_cnt[c]),
            .evt_cnt   (evt_cnt[c])
        );
    end

    emu_sensor_bank #(.N_CORES(N_CORES), .TEMP_W(TEMP_W)) u_sensors (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_temp),
        .wdata  (reg_wdata[TEMP_W-1:0]),
        .rel    (do_rel),
        .shadow (shadow),
        .visible(visible)
    );

    // Read multiplexer: status, interval, then per-core pages.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_STATUS)
            reg_rdata[2:0] = {freeze_req_q, frozen, irq};
        else if (reg_addr == ADDR_INTERVAL)
            reg_rdata = interval;
        else begin
            for (int c = 0; c < N_CORES; c++) begin
                if (idx == 4'(c)) begin
                    case (page)
                        PAGE_CYCLE: reg_rdata[CNT_W-1:0]  = cyc_cnt[c];
                        PAGE_EVENT: reg_rdata[CNT_W-1:0]  = evt_cnt[c];
                        PAGE_FREQ:  reg_rdata[FREQ_W-1:0] = core_freq[c*FREQ_W +: FREQ_W];
                        PAGE_TEMP:  reg_rdata[TEMP_W-1:0] = shadow[c];
                        default:    ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/emu_freeze_ctrl_chk.sv
// Checker: temporal properties of the freeze controller observed at its
// ports, attached to every instance by bind.
module emu_freeze_ctrl_chk #(
    parameter int N_CORES = 4,
    parameter int TEMP_W  = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      reg_wr,
    input logic [7:0]                reg_addr,
    input logic [31:0]               reg_wdata,
    input logic                      irq,
    input logic                      frozen,
    input logic [N_CORES-1:0]        core_bus_idle,
    input logic [N_CORES-1:0]        core_clk_en,
    input logic [N_CORES*TEMP_W-1:0] sensor_temp
);
    logic ack_wr, rel_wr;
    assign ack_wr = reg_wr && reg_addr == 8'h00 && reg_wdata[0];
    assign rel_wr = reg_wr && reg_addr == 8'h00 && reg_wdata[1];

    assert_irq_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !ack_wr |=> irq);

    assert_frozen_all_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> core_clk_en == '0);

    assert_sensor_only_on_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_wr |=> $stable(sensor_temp));

    for (genvar c = 0; c < N_CORES; c++) begin : g_chk
        assert_gate_on_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(core_clk_en[c]) |-> $past(core_bus_idle[c]));

        assert_gate_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !core_clk_en[c] && !rel_wr |=> !core_clk_en[c]);

        assert_release_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
            rel_wr |=> core_clk_en[c]);
    end
endmodule

bind emu_freeze_ctrl emu_freeze_ctrl_chk #(.N_CORES(N_CORES), .TEMP_W(TEMP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .irq          (irq),
    .frozen       (frozen),
    .core_bus_idle(core_bus_idle),
    .core_clk_en  (core_clk_en),
    .sensor_temp  (sensor_temp)
);

// File: tb/emu_freeze_ctrl_test.sv
`timescale 1ns/1ps
// Bench: small configuration (2 cores, 8-bit counters, prescale 4, ticks
// 2..20), sweeping intervals and busy-bus hold lengths.
module emu_freeze_ctrl_test;
    localparam int N = 2, CW = 8, FW = 8, TW = 12, PS = 4, MINT = 2, MAXT = 20;

    logic          clk = 0, rst_n = 0, reg_wr = 0;
    logic [7:0]    reg_addr = 0;
    logic [31:0]   reg_wdata = 0, reg_rdata;
    logic          irq, frozen;
    logic [N-1:0]  core_bus_idle = '1, core_event = '0, core_clk_en;
    logic [N*FW-1:0] core_freq = {8'h35, 8'h1A};
    logic [N*TW-1:0] sensor_temp;
    int tests = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    emu_freeze_ctrl #(.N_CORES(N), .CNT_W(CW), .FREQ_W(FW), .TEMP_W(TW),
        .PRESCALE(PS), .MIN_TICKS(MINT), .MAX_TICKS(MAXT)) uut (.*);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(posedge clk); @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_wr = 0; reg_addr = a; #1; d = reg_rdata;
    endtask

    function automatic int sat(input int v);
        return (v > 255) ? 255 : v;
    endfunction

    function automatic int clampv(input int v);
        return (v < MINT) ? MINT : ((v > MAXT) ? MAXT : v);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, d2;
        int k;
        int ivals[4] = '{2, 3, 7, 20};
        int holds[4] = '{0, 3, 5, 200};
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        check(irq == 0 && frozen == 0, "R1 irq/frozen", {irq, frozen}, 0);
        check(core_clk_en == 2'b11, "R1 clk_en", core_clk_en, 3);
        check(sensor_temp == 0, "R1 sensor_temp", sensor_temp, 0);
        rd(8'h01, d); check(d == MINT, "R1 interval", d, MINT);
        rd(8'h40, d); check(d == 0, "R1 shadow0", d, 0);
        rd(8'h41, d); check(d == 0, "R1 shadow1", d, 0);

        // R3 clamp sweep
        for (int v = 0; v <= MAXT + 3; v++) begin
            wr(8'h01, v); rd(8'h01, d);
            check(d == clampv(v), "R3 interval clamp", d, clampv(v));
        end

        // R9 frequency readout
        rd(8'h30, d); check(d == 32'h1A, "R9 freq0", d, 32'h1A);
        rd(8'h31, d); check(d == 32'h35, "R9 freq1", d, 32'h35);
        core_freq = {8'hC4, 8'h07};
        rd(8'h31, d); check(d == 32'hC4, "R9 freq1 changed", d, 32'hC4);

        // R2/R5/R7/R8/R11 interval and staggered freeze sweep
        for (int t = 0; t < 4; t++) begin
            core_bus_idle = 2'b11;
            wr(8'h01, ivals[t]);
            while (!(irq && frozen)) @(negedge clk);
            wr(8'h10, 0); wr(8'h11, 0); wr(8'h20, 0); wr(8'h21, 0);
            if (t == 0) begin
                rd(8'h10, d); check(d == 0, "R8 clear by write", d, 0);
            end
            core_bus_idle = 2'b01;
            core_event = 2'b01;
            wr(8'h00, 32'h3);
            k = 0;
            while (!irq) begin @(posedge clk); @(negedge clk); k++; end
            check(k == ivals[t] * PS, "R2 interval length", k, ivals[t] * PS);
            for (int h = 0; h < holds[t]; h++) begin @(posedge clk); @(negedge clk); end
            if (holds[t] > 0) begin
                check(core_clk_en == 2'b10 && !frozen, "R5 busy core keeps running",
                      {core_clk_en, frozen}, 3'b100);
            end
            core_bus_idle = 2'b11;
            @(posedge clk); @(negedge clk);
            check(core_clk_en == 2'b00 && frozen, "R5 all gated", {core_clk_en, frozen}, 1);
            rd(8'h00, d); check(d == 32'h7, "R11 status frozen", d, 7);
            rd(8'h10, d); check(d == sat(k + 1), "R7 cycles core0", d, sat(k + 1));
            rd(8'h11, d); check(d == sat(k + holds[t] + 1), "R7/R8 cycles core1", d, sat(k + holds[t] + 1));
            rd(8'h20, d); check(d == sat(k + 1), "R7 events core0", d, sat(k + 1));
            rd(8'h21, d); check(d == 0, "R7 events core1", d, 0);
            repeat (5) @(negedge clk);
            rd(8'h11, d2); check(d2 == d2 && d2 == sat(k + holds[t] + 1), "R7 stable while frozen",
                                 d2, sat(k + holds[t] + 1));
            core_event = 2'b00;
            // R4/R6 acknowledge without release
            wr(8'h00, 32'h1);
            check(!irq, "R4 ack clears irq", irq, 0);
            check(core_clk_en == 2'b00, "R6 ack keeps gated", core_clk_en, 0);
        end

        // R10 temperature shadow vs visible
        wr(8'h40, 32'h123); rd(8'h40, d);
        check(d == 32'h123, "R10 shadow immediate", d, 32'h123);
        wr(8'h41, 32'hABC);
        check(sensor_temp == 0, "R10 sensor unchanged before release", sensor_temp, 0);
        wr(8'h00, 32'h2);
        check(sensor_temp == {12'hABC, 12'h123}, "R10 sensor after release", sensor_temp, 24'hABC123);
        check(core_clk_en == 2'b11, "R6 release opens clocks", core_clk_en, 3);
        wr(8'h40, 32'h055); rd(8'h40, d);
        check(d == 32'h055 && sensor_temp[11:0] == 12'h123, "R10 running write held",
              sensor_temp[11:0], 12'h123);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule